// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns the system clock into a periodic single-cycle tick for a serial channel whose receiver oversamples each bit sixteen times. It also produces a square-wave baud clock that changes level on every tick. Software sets the division ratio through a single control word. The word carries a run bit, a 12-bit reload value and a selector for an optional divide-by-16 stage. That stage sits in front of the main counter, so slow rates stay reachable even though the counter is short.

A write to the control word takes effect at the clock edge that samples the write strobe. The count then starts over from the new reload value. The divide-by-16 stage and the baud clock level also start over. When the run bit is clear, every counter is held at its start point and both outputs stay low.

Top module: `baud_tick_gen`

## Requirements
- R1: After synchronous reset, tick_o and baud_o are low and the generator is stopped until a control word with the run bit set is written.
- R2: Control word layout: bit 13 is the run bit, bits 12:1 hold the reload value D (the wanted ratio minus one), and bit 0 selects the extra divide-by-16 stage.
- R3: With bit 0 clear, tick_o is high for exactly one cycle in every D+1 clocks. Counting the first cycle after the write edge as cycle 0, the first tick falls in cycle D.
- R4: With D = 0 and bit 0 clear, tick_o is high in every cycle.
- R5: With bit 0 set, the tick period is 16*(D+1) clocks and the first tick falls in cycle 16*(D+1)-1.
- R6: baud_o is low in cycle 0 and inverts in the cycle after each tick, giving a square wave with twice the tick period.
- R7: While the run bit is clear, tick_o and baud_o stay low whatever the reload value and the divide-by-16 selector hold.
- R8: A write made while a count is under way discards that count. Timing restarts at cycle 0 with the new value, and baud_o is forced low.
- R9: The largest reload value, 4095, gives a period of 4096 clocks without the extra stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_word | input | 14 | Control word (run bit, reload value, divide-by-16 select) |
| tick_o | output | 1 | One-cycle oversampling tick |
| baud_o | output | 1 | Baud clock that toggles on each tick |

## Verification
The generator is driven with random reload values, each paired with a random setting of the divide-by-16 selector. A timing error that appears only when the prescaler is on is therefore distinguished from one that appears only in the direct path. Directed runs cover five further cases:
- A reload of 0, which separates a constant tick from an off-by-one period.
- A reload of 4095, which exposes a truncated counter.
- A run-bit-clear word with a zero reload, which would tick every cycle if the run bit were ignored.
- A rewrite made halfway through a count, which shows whether stale state survives the restart.
- A stop issued while the baud clock is high.

// File: rtl/brg_pkg.sv
package brg_pkg;
    // Width of the reload counter
    localparam int DIV_W     = 12;
    // Control word: run bit, reload value, divide-by-16 select
    localparam int CFG_W     = DIV_W + 2;
    localparam int RUN_BIT   = DIV_W + 1;
    localparam int PRE_BIT   = 0;
    // Extra prescale ratio and its counter width
    localparam int PRE_RATIO = 16;
    localparam int PRE_W     = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;

    // Packed so that the reload value lands in bits DIV_W:1
    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] reload;
        logic             pre_sel;
    } brg_cfg_t;

    function automatic brg_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        return brg_cfg_t'(w);
    endfunction
endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler
    import brg_pkg::*;
#(
    parameter int RATIO = PRE_RATIO,
    parameter int CW    = PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sel,
    output logic ce
);
    generate
        if (RATIO > 1) begin : g_div
            localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || clear || !sel)
                    cnt <= '0;
                else if (cnt == LAST)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            assign ce = sel ? (cnt == LAST) : 1'b1;

            // R5: after the enable strobe of the prescaler, its count wraps to zero
            a_r5_prescale_wrap: assert property (@(posedge clk) disable iff (rst)
                (ce && sel && !clear) |=> (cnt == '0));
        end else begin : g_bypass
            logic unused_sel;
            assign unused_sel = sel ^ clear;
            assign ce = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
    parameter int W = brg_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         ce,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic         at_zero;

    assign at_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (ce)
            cnt <= at_zero ? load_val : cnt - 1'b1;
    end

    assign tick = run && ce && at_zero;

    // R8: a load always restarts the count from the presented value
    a_r8_restart_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

    // R3: with a non-zero reload a tick lasts a single cycle
    a_r3_single_tick: assert property (@(posedge clk) disable iff (rst)
        (tick && (load_val != '0) && !load) |=> !tick);
endmodule

// File: rtl/brg_clkout.sv
module brg_clkout (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic baud
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            baud <= 1'b0;
        else if (tick)
            baud <= ~baud;
    end

    // R6: every tick inverts the baud clock level
    a_r6_toggle: assert property (@(posedge clk) disable iff (rst)
        (tick && !clear) |=> (baud != $past(baud)));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import brg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             tick_o,
    output logic             baud_o
);
    brg_cfg_t         cfg_q;
    brg_cfg_t         cfg_new;
    logic             hold;
    logic             pre_ce;
    logic [DIV_W-1:0] load_val;

    assign cfg_new = decode_cfg(cfg_word);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= cfg_new;
    end

    // Counters restart on a write and stay parked while stopped
    assign hold     = cfg_we || !cfg_q.run;
    assign load_val = cfg_we ? cfg_new.reload : cfg_q.reload;

    brg_prescaler #(.RATIO(PRE_RATIO), .CW(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (hold),
        .sel   (cfg_q.pre_sel),
        .ce    (pre_ce)
    );

    brg_divider #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (hold),
        .load_val (load_val),
        .run      (cfg_q.run),
        .ce       (pre_ce),
        .tick     (tick_o)
    );

    brg_clkout u_out (
        .clk   (clk),
        .rst   (rst),
        .clear (hold),
        .tick  (tick_o),
        .baud  (baud_o)
    );

    // R1: reset leaves both outputs low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!tick_o && !baud_o));

    // R7: a stop word silences both outputs
    a_r7_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_word[RUN_BIT]) |=> (!tick_o && !baud_o));
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [13:0] cfg_word = '0;
    logic        tick_o;
    logic        baud_o;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    baud_tick_gen uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .tick_o(tick_o), .baud_o(baud_o)
    );

    function automatic int period(input int d, input bit pre);
        return (pre ? 16 : 1) * (d + 1);
    endfunction

    function automatic bit exp_tick(input bit en, input int d, input bit pre, input int k);
        if (!en) return 1'b0;
        return ((k + 1) % period(d, pre)) == 0;
    endfunction

    function automatic bit exp_baud(input bit en, input int d, input bit pre, input int k);
        if (!en) return 1'b0;
        return ((k / period(d, pre)) % 2) == 1;
    endfunction

    task automatic check(input string req, input bit act, input bit exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Word layout per R2: run bit 13, reload 12:1, prescale select bit 0
    task automatic write_cfg(input bit en, input int d, input bit pre);
        @(negedge clk);
        cfg_word = {en, d[11:0], pre};
        cfg_we   = 1'b1;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // Compare both outputs for cycles 0..n-1 after the write
    task automatic run_check(input string req, input bit en, input int d, input bit pre, input int n);
        for (int k = 0; k < n; k++) begin
            check(req, tick_o, exp_tick(en, d, pre, k), $sformatf("tick d=%0d pre=%0b k=%0d", d, pre, k));
            check(req, baud_o, exp_baud(en, d, pre, k), $sformatf("baud d=%0d pre=%0b k=%0d", d, pre, k));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", tick_o, 1'b0, "tick in reset");
        check("R1", baud_o, 1'b0, "baud in reset");
        rst = 1'b0;
        repeat (20) begin
            @(negedge clk);
            check("R1", tick_o, 1'b0, "tick after reset");
            check("R1", baud_o, 1'b0, "baud after reset");
        end

        // R4: zero reload ticks every cycle
        write_cfg(1'b1, 0, 1'b0);
        run_check("R4", 1'b1, 0, 1'b0, 40);

        // R7: stopped, with a reload that would otherwise tick constantly
        write_cfg(1'b0, 0, 1'b0);
        run_check("R7", 1'b0, 0, 1'b0, 60);

        // R3: small direct ratios
        write_cfg(1'b1, 1, 1'b0);
        run_check("R3", 1'b1, 1, 1'b0, 30);
        write_cfg(1'b1, 6, 1'b0);
        run_check("R3", 1'b1, 6, 1'b0, 50);

        // R5: prescaled ratios, including reload 0
        write_cfg(1'b1, 0, 1'b1);
        run_check("R5", 1'b1, 0, 1'b1, 80);
        write_cfg(1'b1, 2, 1'b1);
        run_check("R5", 1'b1, 2, 1'b1, 200);

        // R8: rewrite in the middle of a long count, and while baud is high
        write_cfg(1'b1, 9, 1'b0);
        repeat (15) @(negedge clk);
        write_cfg(1'b1, 3, 1'b0);
        run_check("R8", 1'b1, 3, 1'b0, 30);
        write_cfg(1'b1, 4, 1'b1);
        repeat (100) @(negedge clk);
        write_cfg(1'b1, 5, 1'b0);
        run_check("R8", 1'b1, 5, 1'b0, 30);

        // R7: stop while baud clock is high
        write_cfg(1'b1, 2, 1'b0);
        repeat (4) @(negedge clk);
        check("R6", baud_o, 1'b1, "baud high before stop");
        write_cfg(1'b0, 2, 1'b0);
        run_check("R7", 1'b0, 2, 1'b0, 30);

        // R9: largest reload
        write_cfg(1'b1, 4095, 1'b0);
        run_check("R9", 1'b1, 4095, 1'b0, 8200);

        // R6 with R3/R5: random reloads and prescale selection
        for (int t = 0; t < 24; t++) begin
            int d;
            bit p;
            d = int'($urandom % 40);
            p = bit'($urandom % 2);
            write_cfg(1'b1, d, p);
            run_check(p ? "R5" : "R3", 1'b1, d, p, 2 * period(d, p) + 3);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule